// File: doc/BRIEF.md
# Two-Wire Bit Clock Phase Generator

This block is the bit timer of a two-wire serial master. It turns the system clock into the low and high halves of each serial clock bit. It drives the clock line low for the low half, then releases it for the high half. The transfer engine beside it gets one-cycle strobes that mark the clock fall, the point where the data line may change, the clock rise, the data sampling point and the last cycle of the bit.

Each half lasts `mantissa * 2^exponent + OFFSET` system clocks. The configuration word holds one exponent, shared by both halves, and a separate 8-bit mantissa for each half. OFFSET and the largest legal exponent are build parameters. A target device may hold the clock line low after it has been released. The high half is only counted on cycles where the line is seen high, so this stretching lengthens the bit and never eats into the high time. The engine keeps `bit_req` asserted to run bits back to back. Bits start without a gap, and the generator falls idle with the line released once the request is gone.

Top module: `sclk_phase_gen`

## Requirements
- R1: After reset, and whenever no bit is running, `scl_drive_low` is 0 and every strobe output is 0.
- R2: The low half lasts exactly `(lo_mant << e) + OFFSET` cycles of `scl_drive_low` = 1. `lo_mant` is `cfg_word[7:0]` and the exponent field `e` is `cfg_word[18:16]`.
- R3: The high half counts exactly `(hi_mant << e) + OFFSET` cycles in which `scl_in` is 1 at the clock edge. `hi_mant` is `cfg_word[15:8]`.
- R4: An exponent field above MAX_EXP (default 5) is treated as MAX_EXP.
- R5: While the generator is in the high half and `scl_in` is 0, the high count does not advance. The high half from `stb_rise` through `stb_end` therefore lasts `(hi_mant << e) + OFFSET` plus the number of stretched cycles.
- R6: `stb_fall` pulses in the first cycle of `scl_drive_low` = 1. `stb_rise` pulses in the first cycle after the low half, with the line released.
- R7: `stb_change` pulses in low-half cycle index `len_lo >> 1`, counted from 0. `stb_sample` pulses in counted high cycle index `len_hi >> 1`, counted from 0.
- R8: `stb_end` pulses in the last counted high cycle. If `bit_req` is 1 in that cycle, the next cycle starts a new bit, with `stb_fall` = 1.
- R9: `cfg_word` is sampled only in the cycle that starts a bit. Changes made during a bit do not alter that bit's timing.
- R10: A started bit always runs to completion, even if `bit_req` drops. If `bit_req` is 0 at `stb_end`, the generator goes idle with the line released.
- R11: At most one of the five strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_req | input | 1 | Engine requests a bit; held high to run bits back to back |
| cfg_word | input | 19 | Low mantissa [7:0], high mantissa [15:8], shared exponent [18:16] |
| scl_in | input | 1 | Synchronised level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the clock line low; 0 releases it |
| stb_fall | output | 1 | First cycle of the low half |
| stb_change | output | 1 | Middle of the low half; the data line may change |
| stb_rise | output | 1 | First cycle of the high half; the line is released |
| stb_sample | output | 1 | Middle of the counted high half; sample the data line |
| stb_end | output | 1 | Last counted cycle of the bit |

## Verification
The hardest case to reach is a target that stretches the clock, with the hold starting in the same cycle the line is released. That cycle must not be counted, and the sampling point must move with the hold. The bench models the clock line as a wired-AND of the generator and a target. The driver task asserts the target hold just after it sees `stb_rise` and keeps it for a chosen number of cycles. It also writes a junk configuration during every bit, and it clears the request right after a bit starts. These cover the configuration-latch and run-to-completion cases.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } sclk_phase_e;

endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode #(
   parameter int MANT_W  = 8,
   parameter int EXP_W   = 3,
   parameter int MAX_EXP = 5,
   parameter int OFFSET  = 4,
   parameter int LEN_W   = 13
) (
   input  logic [2*MANT_W+EXP_W-1:0] cfg,
   output logic [LEN_W-1:0]          len_lo,
   output logic [LEN_W-1:0]          len_hi
);
   localparam int EXP_LSB = 2 * MANT_W;
   localparam int PAD_W   = LEN_W - MANT_W;

   logic [1:0][MANT_W-1:0] mant;
   logic [1:0][LEN_W-1:0]  lens;
   logic [EXP_W-1:0]       e_raw;
   logic [EXP_W-1:0]       e_eff;

   assign mant[0] = cfg[MANT_W-1:0];
   assign mant[1] = cfg[2*MANT_W-1:MANT_W];
   assign e_raw   = cfg[EXP_LSB+EXP_W-1:EXP_LSB];

   // R4: clamp only when the field can encode more than MAX_EXP
   generate
      if (MAX_EXP >= (1 << EXP_W) - 1) begin : g_noclamp
         assign e_eff = e_raw;
      end else begin : g_clamp
         assign e_eff = (e_raw > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : e_raw;
      end
   endgenerate

   generate
      for (genvar i = 0; i < 2; i++) begin : g_ph
         assign lens[i] = ({{PAD_W{1'b0}}, mant[i]} << e_eff) + LEN_W'(OFFSET);
      end
   endgenerate

   assign len_lo = lens[0];
   assign len_hi = lens[1];

endmodule

// File: rtl/sclk_phase_timer.sv
module sclk_phase_timer #(
   parameter int LEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             en,
   output logic             mid,
   output logic             last
);
   logic [LEN_W-1:0] k_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] half_q;
   logic             at_end;

   assign at_end = (k_q == len_q - 1'b1);
   assign last   = en && at_end;
   assign mid    = en && (k_q == half_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q    <= '0;
         len_q  <= '1;
         half_q <= '0;
      end else if (load) begin
         k_q    <= '0;
         len_q  <= len;
         half_q <= len >> 1;
      end else if (en && !at_end) begin
         k_q <= k_q + 1'b1;
      end
   end

   // R5: a phase does not advance while its enable is low (stretch hold)
   p_hold_when_off_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(k_q));

   // R2 / R3: an enabled phase never runs past its programmed length
   p_within_len_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (k_q < len_q));

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
   import sclk_pkg::*;
#(
   parameter int MANT_W  = 8,
   parameter int EXP_W   = 3,
   parameter int MAX_EXP = 5,
   parameter int OFFSET  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bit_req,
   input  logic [2*MANT_W+EXP_W-1:0] cfg_word,
   input  logic                      scl_in,
   output logic                      scl_drive_low,
   output logic                      stb_fall,
   output logic                      stb_change,
   output logic                      stb_rise,
   output logic                      stb_sample,
   output logic                      stb_end
);
   localparam int MAX_LEN = ((2 ** MANT_W) - 1) * (2 ** MAX_EXP) + OFFSET;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);
   localparam int T_LO    = 0;
   localparam int T_HI    = 1;

   generate
      if (OFFSET < 3) begin : g_bad_offset
         $error("OFFSET must be at least 3 so that strobes never coincide");
      end
      if (MAX_EXP < 1 || MAX_EXP >= (1 << EXP_W)) begin : g_bad_exp
         $error("MAX_EXP must be at least 1 and fit in the exponent field");
      end
      if (MANT_W < 1) begin : g_bad_mant
         $error("MANT_W must be positive");
      end
   endgenerate

   sclk_phase_e state_q, state_d;
   logic [LEN_W-1:0] len_lo, len_hi;
   logic [1:0][LEN_W-1:0] len_v;
   logic [1:0] en_v, mid_v, last_v;
   logic bit_start;
   logic fall_q, rise_q;

   sclk_cfg_decode #(
      .MANT_W (MANT_W),
      .EXP_W  (EXP_W),
      .MAX_EXP(MAX_EXP),
      .OFFSET (OFFSET),
      .LEN_W  (LEN_W)
   ) u_dec (
      .cfg   (cfg_word),
      .len_lo(len_lo),
      .len_hi(len_hi)
   );

   assign len_v[T_LO] = len_lo;
   assign len_v[T_HI] = len_hi;
   assign en_v[T_LO]  = (state_q == PH_LOW);
   assign en_v[T_HI]  = (state_q == PH_HIGH) && scl_in;

   // R9: both phase lengths are captured together, only at bit start
   assign bit_start = bit_req &&
                      ((state_q == PH_IDLE) ||
                       ((state_q == PH_HIGH) && last_v[T_HI]));

   generate
      for (genvar i = 0; i < 2; i++) begin : g_tmr
         sclk_phase_timer #(.LEN_W(LEN_W)) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .load (bit_start),
            .len  (len_v[i]),
            .en   (en_v[i]),
            .mid  (mid_v[i]),
            .last (last_v[i])
         );
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_IDLE: if (bit_req) state_d = PH_LOW;
         PH_LOW:  if (last_v[T_LO]) state_d = PH_HIGH;
         PH_HIGH: if (last_v[T_HI]) state_d = bit_req ? PH_LOW : PH_IDLE;
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         fall_q  <= 1'b0;
         rise_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         fall_q  <= bit_start;
         rise_q  <= (state_q == PH_LOW) && last_v[T_LO];
      end
   end

   assign scl_drive_low = (state_q == PH_LOW);
   assign stb_fall      = fall_q;
   assign stb_rise      = rise_q;
   assign stb_change    = mid_v[T_LO];
   assign stb_sample    = mid_v[T_HI];
   assign stb_end       = last_v[T_HI];

   // R11: strobes never overlap
   p_strobe_excl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stb_fall, stb_change, stb_rise, stb_sample, stb_end}));

   // R6: the fall strobe marks a driven-low cycle, the rise strobe a released one
   p_fall_is_low_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      stb_fall |-> scl_drive_low);
   p_rise_is_released_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      stb_rise |-> !scl_drive_low);

   // R7: sampling only ever happens on a released, high line
   p_sample_on_high_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      stb_sample |-> (!scl_drive_low && scl_in));

   // R8: a held request chains the next bit without a gap
   p_back_to_back_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb_end && bit_req) |=> stb_fall);

   // R10: without a request the bit ends into idle with the line released
   p_end_to_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb_end && !bit_req) |=> (!scl_drive_low && !stb_fall));

endmodule

// File: tb/sclk_phase_gen_bench.sv
module sclk_phase_gen_bench;
   localparam int TB_OFF  = 4;
   localparam int TB_MAXE = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_req = 1'b0;
   logic [18:0] cfg_word = '0;
   logic        stretch = 1'b0;
   logic        scl_line;
   logic        scl_drive_low, stb_fall, stb_change, stb_rise, stb_sample, stb_end;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      int lo;
      int hi;
      int chg;
      int smp;
      bit nxt;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   // wired-AND clock line: generator pull-down or a stretching target
   assign scl_line = !(scl_drive_low || stretch);

   sclk_phase_gen #(
      .MANT_W (8),
      .EXP_W  (3),
      .MAX_EXP(TB_MAXE),
      .OFFSET (TB_OFF)
   ) u_sclk_phase_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_req      (bit_req),
      .cfg_word     (cfg_word),
      .scl_in       (scl_line),
      .scl_drive_low(scl_drive_low),
      .stb_fall     (stb_fall),
      .stb_change   (stb_change),
      .stb_rise     (stb_rise),
      .stb_sample   (stb_sample),
      .stb_end      (stb_end)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int phase_len(input int m, input int e);
      int ee;
      ee = (e > TB_MAXE) ? TB_MAXE : e;   // R4 clamp
      return (m << ee) + TB_OFF;
   endfunction

   task automatic tick;
      @(negedge clk);
      #1;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // driver: one bit per call; pushes the expected timing first
   task automatic send_bit(input int lo, input int hi, input int e,
                           input int hold, input bit last);
      exp_t it;
      int   llo, lhi;
      llo    = phase_len(lo, e);
      lhi    = phase_len(hi, e);
      it.lo  = llo;
      it.hi  = lhi + hold;
      it.chg = llo >> 1;
      it.smp = lhi >> 1;
      it.nxt = !last;
      q.push_back(it);
      cfg_word = {e[2:0], hi[7:0], lo[7:0]};
      bit_req  = 1'b1;
      do tick(); while (!stb_fall);
      if (last) bit_req = 1'b0;               // R10: request dropped mid-bit
      cfg_word = 19'h5_A5C3 ^ cfg_word;       // R9: junk during the bit
      while (!stb_rise) tick();
      if (hold > 0) begin
         stretch = 1'b1;                      // R5: target holds the line
         repeat (hold) tick();
         stretch = 1'b0;
      end
      while (!stb_end) tick();
   endtask

   // monitor: measures each bit and compares it with the queue
   int  ph = 0;
   int  lo_n, hi_n, cnt_n, chg_at, smp_at;
   bit  chk_next = 1'b0;
   bit  exp_nxt  = 1'b0;
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         if (chk_next) begin
            chk_next = 1'b0;
            if (exp_nxt)
               chk(stb_fall, "R8 back-to-back fall", int'(stb_fall), 1);
            else
               chk(!stb_fall && !scl_drive_low, "R10 idle after last bit",
                   int'(stb_fall || scl_drive_low), 0);
         end
         if (stb_fall) begin
            chk(scl_drive_low, "R6 fall with line low", int'(scl_drive_low), 1);
            ph = 1; lo_n = 0; chg_at = -1;
         end
         if (stb_rise) begin
            chk(!scl_drive_low, "R6 rise with line released", int'(scl_drive_low), 0);
            ph = 2; hi_n = 0; cnt_n = 0; smp_at = -1;
         end
         if (ph == 1) begin
            if (stb_change) chg_at = lo_n;
            if (scl_drive_low) lo_n++;
         end else if (ph == 2) begin
            if (stb_sample) smp_at = cnt_n;
            hi_n++;
            if (scl_line) cnt_n++;
            if (stb_end) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R8 unexpected bit end", 1, 0);
               end else begin
                  exp_t it;
                  it = q.pop_front();
                  chk(lo_n == it.lo, "R2/R4/R9 low length", lo_n, it.lo);
                  chk(hi_n == it.hi, "R3/R5 high length", hi_n, it.hi);
                  chk(chg_at == it.chg, "R7 change point", chg_at, it.chg);
                  chk(smp_at == it.smp, "R7 sample point", smp_at, it.smp);
                  chk_next = 1'b1;
                  exp_nxt  = it.nxt;
               end
               ph = 0;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      // R1: reset / idle state
      repeat (4) begin
         tick();
         chk(!scl_drive_low && !stb_fall && !stb_change && !stb_rise &&
             !stb_sample && !stb_end, "R1 idle after reset",
             int'({scl_drive_low, stb_fall, stb_change, stb_rise, stb_sample, stb_end}), 0);
      end
      // back-to-back chain with the request held (R8)
      send_bit(10, 10, 0, 0, 1'b0);   // 14 / 14
      send_bit(3, 7, 2, 0, 1'b0);     // 16 / 32
      send_bit(0, 0, 3, 0, 1'b0);     // mantissa 0: 4 / 4
      send_bit(5, 2, 7, 7, 1'b0);     // R4 clamp to 5: 164 / 68, stretched 7
      send_bit(20, 9, 1, 25, 1'b1);   // R5 long stretch, last bit
      tick();
      repeat (6) begin
         tick();
         chk(!scl_drive_low && !stb_fall, "R1 idle between bits",
             int'(scl_drive_low || stb_fall), 0);
      end
      send_bit(255, 255, 5, 3, 1'b1); // largest: 8164 / 8164
      repeat (5) tick();
      chk(q.size() == 0, "R8 all bits observed", q.size(), 0);
      summary();
      $finish;
   end

endmodule